// File: doc/BRIEF.md
# Ethernet Receive Delimiter Stripper

This block sits at the head of an Ethernet MAC receive path, after the media interface has already assembled nibbles into bytes. It watches a byte stream qualified by a data-valid strobe. While the line is quiet or carrying preamble it forwards nothing. When it sees the start-of-frame delimiter it switches to frame mode. From that point it passes every byte downstream with one cycle of latency, beginning with the first destination-address byte. It also runs each byte through a CRC-32 checker.

When data-valid falls, the frame is over. One cycle later the block raises a single status strobe carrying the CRC verdict and the number of bytes received after the delimiter, FCS included. If timestamping is enabled when the delimiter arrives, the value of a free-running system-time counter is latched at that moment and released with the status. An upstream address filter can pulse a drop input at any time during the frame. A dropped frame produces neither status nor timestamp.

Top module: `eth_rx_sfd_strip`

## Requirements
- R1: After reset all output strobes are low, and no byte is forwarded while `rx_dv` is low, whatever `rx_data` carries.
- R2: Preamble bytes (0x55) and the delimiter byte (0xD5) are never forwarded; the delimiter is accepted after zero or more preamble bytes.
- R3: If a byte other than 0x55 or 0xD5 appears while hunting for the delimiter, the rest of that burst is ignored until `rx_dv` goes low, even if 0xD5 follows.
- R4: Each byte after the delimiter appears on `out_data` with `out_valid` one cycle after it was sampled, in order; `out_sof` is high with the first such byte only.
- R5: The first cycle in which `rx_dv` is low in frame mode ends the frame; one cycle later `stat_valid` pulses for exactly one cycle with `stat_len` equal to the number of bytes after the delimiter, FCS included.
- R6: `stat_crc_err` is 0 exactly when the CRC-32 over all frame bytes is correct. The CRC uses polynomial 0x04C11DB7, an all-ones preset and LSB-first bit order, and the FCS is sent complemented with its low byte first. In reflected form the remainder of a good frame is 0xDEBB20E3.
- R7: If `ts_en` is high in the cycle the delimiter is sampled, `ts_valid` pulses together with `stat_valid` and `ts_value` holds the `sys_time` sampled in that cycle; if `ts_en` is low, `ts_valid` stays low.
- R8: A `drop_req` pulse in any cycle of frame mode suppresses both `stat_valid` and `ts_valid` for that frame only. Frame mode runs from the cycle after the delimiter through the cycle `rx_dv` is first low.
- R9: A delimiter followed at once by `rx_dv` low gives a status with `stat_len` 0 and `stat_crc_err` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Byte stream valid |
| rx_data | input | 8 | Received byte |
| drop_req | input | 1 | Filter reject pulse for the current frame |
| ts_en | input | 1 | Enable timestamp capture at the delimiter |
| sys_time | input | TS_W (32) | Free-running system time |
| out_valid | output | 1 | Forwarded byte valid |
| out_data | output | 8 | Forwarded byte |
| out_sof | output | 1 | First forwarded byte of a frame |
| stat_valid | output | 1 | End-of-frame status strobe |
| stat_crc_err | output | 1 | CRC check failed |
| stat_len | output | LEN_W (16) | Bytes after the delimiter |
| ts_valid | output | 1 | Timestamp valid |
| ts_value | output | TS_W (32) | Captured system time |

## Verification
The bench targets the hunt-phase corners: a delimiter with no preamble in front of it, a junk byte ahead of a delimiter in the same burst, and 0xD5 on the bus while valid is low. A design that accepted the junk-then-delimiter case would forward a frame where none may start. A design that demanded preamble would lose the bare frame. The bench also targets the frame end. It checks that status lands exactly one cycle after valid falls and that the byte count excludes the delimiter, since an off-by-one there shows up directly in `stat_len`. A good and a corrupted FCS, a zero-length frame, a dropped frame followed by a clean one, and a frame with timestamping off are each used to show that the CRC verdict, the drop suppression and the timestamp all stay confined to their own frame.

// File: rtl/eth_rx_pkg.sv
package eth_rx_pkg;

   typedef enum logic [1:0] {
      ST_HUNT  = 2'd0,
      ST_SKIP  = 2'd1,
      ST_FRAME = 2'd2
   } rx_state_e;

   localparam logic [7:0]  PRE_BYTE   = 8'h55;
   localparam logic [7:0]  SFD_BYTE   = 8'hD5;
   localparam logic [31:0] CRC_POLY   = 32'h04C11DB7;

   function automatic logic [31:0] bitrev32(input logic [31:0] v);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = v[31-i];
      return r;
   endfunction

   // One byte through a reflected (LSB-first) CRC-32 register.
   function automatic logic [31:0] crc_byte_refl(input logic [31:0] c_in,
                                                 input logic [7:0]  d);
      logic [31:0] c;
      logic        fb;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         fb = c[0] ^ d[i];
         c  = {1'b0, c[31:1]} ^ (fb ? bitrev32(CRC_POLY) : 32'h0);
      end
      return c;
   endfunction

endpackage

// File: rtl/eth_rx_crc32.sv
module eth_rx_crc32
   import eth_rx_pkg::*;
#(
   parameter logic [31:0] GOOD_RESIDUE = 32'hC704DD7B
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init,
   input  logic       en,
   input  logic [7:0] din,
   output logic       crc_ok
);
   localparam logic [31:0] RESIDUE_REFL = bitrev32(GOOD_RESIDUE);

   logic [31:0] crc_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      crc_q <= '1;
      else if (init)   crc_q <= '1;
      else if (en)     crc_q <= crc_byte_refl(crc_q, din);
   end

   assign crc_ok = (crc_q == RESIDUE_REFL);

   // R6: a freshly preset register never reads as a good frame.
   p_preset_not_good_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init) |-> !crc_ok);

endmodule

// File: rtl/eth_rx_ts_snap.sv
module eth_rx_ts_snap #(
   parameter int TS_W   = 32,
   parameter bit HAS_TS = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cap_evt,
   input  logic            ts_en,
   input  logic [TS_W-1:0] sys_time,
   input  logic            release_evt,
   output logic            ts_valid,
   output logic [TS_W-1:0] ts_value
);
   generate
      if (HAS_TS) begin : g_ts
         logic            armed_q;
         logic [TS_W-1:0] snap_q;
         logic            vld_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               armed_q <= 1'b0;
               snap_q  <= '0;
               vld_q   <= 1'b0;
            end else begin
               vld_q <= release_evt && armed_q;
               if (cap_evt) begin
                  armed_q <= ts_en;
                  if (ts_en) snap_q <= sys_time;
               end else if (release_evt) begin
                  armed_q <= 1'b0;
               end
            end
         end

         assign ts_valid = vld_q;
         assign ts_value = snap_q;

         // R7: the snapshot does not move between delimiter and release.
         p_snap_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed_q && !cap_evt) |=> $stable(snap_q));
      end else begin : g_no_ts
         assign ts_valid = 1'b0;
         assign ts_value = '0;
      end
   endgenerate

endmodule

// File: rtl/eth_rx_sfd_strip.sv
module eth_rx_sfd_strip
   import eth_rx_pkg::*;
#(
   parameter int TS_W   = 32,
   parameter int LEN_W  = 16,
   parameter bit HAS_TS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_dv,
   input  logic [7:0]       rx_data,
   input  logic             drop_req,
   input  logic             ts_en,
   input  logic [TS_W-1:0]  sys_time,
   output logic             out_valid,
   output logic [7:0]       out_data,
   output logic             out_sof,
   output logic             stat_valid,
   output logic             stat_crc_err,
   output logic [LEN_W-1:0] stat_len,
   output logic             ts_valid,
   output logic [TS_W-1:0]  ts_value
);
   localparam logic [LEN_W-1:0] LEN_MAX = '1;

   generate
      if (LEN_W < 4 || TS_W < 1) begin : g_bad_param
         initial $fatal(1, "eth_rx_sfd_strip: LEN_W must be >= 4 and TS_W >= 1");
      end
   endgenerate

   rx_state_e        state_q, state_d;
   logic             first_q, drop_q;
   logic [LEN_W-1:0] len_q;
   logic             crc_ok;

   wire sfd_hit    = (state_q == ST_HUNT)  && rx_dv && (rx_data == SFD_BYTE);
   wire byte_take  = (state_q == ST_FRAME) && rx_dv;
   wire frame_end  = (state_q == ST_FRAME) && !rx_dv;
   wire drop_now   = drop_q || ((state_q == ST_FRAME) && drop_req);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_HUNT: if (rx_dv) begin
            if (rx_data == SFD_BYTE)      state_d = ST_FRAME;
            else if (rx_data != PRE_BYTE) state_d = ST_SKIP;
         end
         ST_SKIP:  if (!rx_dv) state_d = ST_HUNT;
         ST_FRAME: if (!rx_dv) state_d = ST_HUNT;
         default:  state_d = ST_HUNT;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_HUNT;
         first_q      <= 1'b0;
         drop_q       <= 1'b0;
         len_q        <= '0;
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_sof      <= 1'b0;
         stat_valid   <= 1'b0;
         stat_crc_err <= 1'b0;
         stat_len     <= '0;
      end else begin
         state_q    <= state_d;
         out_valid  <= byte_take;
         out_sof    <= byte_take && first_q;
         stat_valid <= frame_end && !drop_now;
         if (byte_take) out_data <= rx_data;
         if (sfd_hit) begin
            first_q <= 1'b1;
            drop_q  <= 1'b0;
            len_q   <= '0;
         end else begin
            if (byte_take) begin
               first_q <= 1'b0;
               if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
            end
            if ((state_q == ST_FRAME) && drop_req) drop_q <= 1'b1;
         end
         if (frame_end) begin
            stat_crc_err <= !crc_ok;
            stat_len     <= len_q;
         end
      end
   end

   eth_rx_crc32 u_crc (
      .clk    (clk),
      .rst_n  (rst_n),
      .init   (sfd_hit),
      .en     (byte_take),
      .din    (rx_data),
      .crc_ok (crc_ok)
   );

   eth_rx_ts_snap #(.TS_W(TS_W), .HAS_TS(HAS_TS)) u_ts (
      .clk         (clk),
      .rst_n       (rst_n),
      .cap_evt     (sfd_hit),
      .ts_en       (ts_en),
      .sys_time    (sys_time),
      .release_evt (frame_end && !drop_now),
      .ts_valid    (ts_valid),
      .ts_value    (ts_value)
   );

   // R4: a forwarded byte always follows a sampled valid byte.
   p_out_after_dv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(rx_dv));
   // R4: start marker only rides on a forwarded byte.
   p_sof_with_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);
   // R5: status follows a low valid and is a single pulse.
   p_stat_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |-> $past(!rx_dv));
   p_stat_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_valid |=> !stat_valid);
   // R7: timestamp is never released without status.
   p_ts_with_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |-> stat_valid);
   // R1: no forwarding while the stream was idle.
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!rx_dv) |-> !out_valid);

endmodule

// File: tb/tb_eth_rx_sfd_strip.sv
module tb_eth_rx_sfd_strip;
   localparam int TS_W  = 32;
   localparam int LEN_W = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             rx_dv = 1'b0;
   logic [7:0]       rx_data = '0;
   logic             drop_req = 1'b0;
   logic             ts_en = 1'b0;
   logic [TS_W-1:0]  sys_time = 32'h1000;
   logic             out_valid, out_sof, stat_valid, stat_crc_err, ts_valid;
   logic [7:0]       out_data;
   logic [LEN_W-1:0] stat_len;
   logic [TS_W-1:0]  ts_value;

   always #2.5 clk = ~clk;

   eth_rx_sfd_strip #(.TS_W(TS_W), .LEN_W(LEN_W), .HAS_TS(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_data(rx_data),
      .drop_req(drop_req), .ts_en(ts_en), .sys_time(sys_time),
      .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
      .stat_valid(stat_valid), .stat_crc_err(stat_crc_err), .stat_len(stat_len),
      .ts_valid(ts_valid), .ts_value(ts_value)
   );

   int n_checks = 0;
   int n_fail   = 0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor state, filled by cyc()
   logic [7:0] got [0:127];
   int ngot, nsof, sof_idx, nstat, st_len, st_err, st_call, nts, ncall;
   logic [TS_W-1:0] ts_got;

   task automatic mon_clear();
      ngot = 0; nsof = 0; sof_idx = -1; nstat = 0; st_len = -1; st_err = -1;
      st_call = -1; nts = 0; ts_got = '0;
   endtask

   // one clock: sample outputs of the previous edge, then drive new inputs
   task automatic cyc(input bit dv, input logic [7:0] d, input bit drp);
      @(negedge clk);
      ncall++;
      if (out_valid) begin
         if (out_sof) begin nsof++; sof_idx = ngot; end
         if (ngot < 128) got[ngot] = out_data;
         ngot++;
      end
      if (stat_valid) begin
         nstat++; st_len = int'(stat_len); st_err = int'(stat_crc_err); st_call = ncall;
      end
      if (ts_valid) begin nts++; ts_got = ts_value; end
      rx_dv    = dv;
      rx_data  = d;
      drop_req = drp;
      sys_time = sys_time + 32'd3;
   endtask

   function automatic logic [31:0] ref_fcs(input logic [7:0] b [0:63], input int n);
      logic [31:0] c = 32'hFFFF_FFFF;
      logic [31:0] r;
      for (int k = 0; k < n; k++)
         for (int i = 0; i < 8; i++) begin
            logic fb = c[31] ^ b[k][i];
            c = {c[30:0], 1'b0} ^ (fb ? 32'h04C11DB7 : 32'h0);
         end
      for (int i = 0; i < 32; i++) r[i] = c[31-i];
      return ~r;
   endfunction

   // full frame scenario: npre preamble bytes, nbody payload bytes + FCS
   task automatic run_frame(input int npre, input int nbody, input bit fcs_good,
                            input bit tsen, input int drop_at, input string name);
      logic [7:0]  fr [0:63];
      logic [31:0] fcs;
      logic [TS_W-1:0] t_sfd;
      int n, end_call;
      bit exp_stat;
      mon_clear();
      for (int k = 0; k < nbody; k++) fr[k] = 8'((k * 37 + nbody * 11 + 5) & 8'hFF);
      fcs = ref_fcs(fr, nbody);
      if (!fcs_good) fcs = fcs ^ 32'h0000_0100;
      for (int k = 0; k < 4; k++) fr[nbody + k] = fcs[8*k +: 8];
      n = nbody + 4;
      ts_en = tsen;
      for (int k = 0; k < npre; k++) cyc(1'b1, 8'h55, 1'b0);
      cyc(1'b1, 8'hD5, 1'b0);
      t_sfd = sys_time;
      for (int k = 0; k < n; k++) cyc(1'b1, fr[k], (k == drop_at));
      cyc(1'b0, 8'h00, 1'b0);
      end_call = ncall;
      for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 1'b0);
      exp_stat = (drop_at < 0);
      chk(ngot == n, {name, " R2 R4 forwarded count"}, ngot, n);
      begin
         bit same = 1'b1;
         for (int k = 0; k < n && k < ngot; k++) if (got[k] !== fr[k]) same = 1'b0;
         chk(same && got[0] === fr[0], {name, " R4 byte order from DA"}, got[0], fr[0]);
      end
      chk(nsof == 1 && sof_idx == 0, {name, " R4 sof on first byte"}, sof_idx, 0);
      chk(nstat == int'(exp_stat), {name, " R5 R8 status count"}, nstat, exp_stat);
      if (exp_stat) begin
         chk(st_call == end_call + 1, {name, " R5 status timing"}, st_call, end_call + 1);
         chk(st_len == n, {name, " R5 length"}, st_len, n);
         chk(st_err == int'(!fcs_good), {name, " R6 crc flag"}, st_err, !fcs_good);
      end
      chk(nts == int'(exp_stat && tsen), {name, " R7 R8 ts count"}, nts, exp_stat && tsen);
      if (exp_stat && tsen)
         chk(ts_got == t_sfd, {name, " R7 ts value"}, ts_got, t_sfd);
   endtask

   task automatic t_reset();
      chk(!out_valid && !out_sof && !stat_valid && !ts_valid, "R1 reset outputs",
          {out_valid, out_sof, stat_valid, ts_valid}, 0);
   endtask

   task automatic t_idle_noise();
      mon_clear();
      for (int k = 0; k < 6; k++) cyc(1'b0, (k[0] ? 8'hD5 : 8'h55), 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      chk(ngot == 0 && nstat == 0, "R1 idle bytes ignored", ngot + nstat, 0);
   endtask

   task automatic t_junk_then_sfd();
      mon_clear();
      cyc(1'b1, 8'h55, 1'b0);
      cyc(1'b1, 8'h12, 1'b0);
      cyc(1'b1, 8'hD5, 1'b0);
      for (int k = 0; k < 6; k++) cyc(1'b1, 8'(k + 1), 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 1'b0);
      chk(ngot == 0, "R3 junk burst not forwarded", ngot, 0);
      chk(nstat == 0, "R3 junk burst no status", nstat, 0);
   endtask

   task automatic t_zero_len();
      mon_clear();
      ts_en = 1'b0;
      cyc(1'b1, 8'h55, 1'b0);
      cyc(1'b1, 8'hD5, 1'b0);
      cyc(1'b0, 8'h00, 1'b0);
      for (int k = 0; k < 3; k++) cyc(1'b0, 8'h00, 1'b0);
      chk(ngot == 0, "R9 empty frame no bytes", ngot, 0);
      chk(nstat == 1 && st_len == 0, "R9 empty frame length", st_len, 0);
      chk(st_err == 1, "R9 empty frame crc error", st_err, 1);
   endtask

   initial begin : watchdog
      #400000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      ncall = 0;
      mon_clear();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_idle_noise();
      run_frame(7, 20, 1'b1, 1'b1, -1, "good");
      run_frame(7, 12, 1'b0, 1'b1, -1, "badfcs");
      run_frame(0, 8,  1'b1, 1'b1, -1, "nopre");
      t_junk_then_sfd();
      run_frame(3, 16, 1'b1, 1'b1, 5, "dropped");
      run_frame(2, 10, 1'b1, 1'b1, -1, "after_drop");
      run_frame(7, 14, 1'b1, 1'b0, -1, "ts_off");
      run_frame(1, 9,  1'b1, 1'b1, 12, "drop_in_fcs");
      t_zero_len();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule